// File: doc/BRIEF.md
# Prioritized Exception Dispatcher

This block sits beside the sequencer of a small DSP core and decides when the core leaves its instruction stream for an exception handler. It holds one pending flag per exception level. Raise strobes set these flags. A gated mailbox interrupt from the core's control register can also set the flag for its own level. On a check strobe the block picks at most one pending level and hands the sequencer a jump target. It also supplies the two words that must be saved: the current program counter and the current status word. Each of them goes to its own hardware stack.

Only one handler runs at a time. Once a level is dispatched, the block records that an exception is in progress and makes no further dispatch until a return-from-interrupt strobe arrives. The return path that pops the stacks lives outside the block. Level 0 can be marked pending but is never chosen by the scan. The mailbox level bypasses the global enable bit of the status word.

Top module: `exc_dispatch`

## Requirements
- R1: A one on bit n of `raise_i` at a clock edge sets pending level n. The other pending levels keep their values.
- R2: When `ext_flag_i` is high and status bit 11 (external enable) is high, `ext_clr_o` is high in that same cycle and the mailbox level (default 5) becomes pending at the next edge. Otherwise `ext_clr_o` is low and nothing is set.
- R3: No dispatch (`pc_load_o` low) occurs while no level is pending.
- R4: No dispatch occurs while an exception is in progress. Every pending level is kept until the in-progress state is released.
- R5: Among eligible pending levels, the highest level from 7 down to 1 is dispatched, and only that one.
- R6: Level 0 is never dispatched, even when it is pending and enabled.
- R7: A pending level is eligible when status bit 9 (global enable) is set. The mailbox level is eligible even when bit 9 is clear. An ineligible level stays pending.
- R8: In the dispatch cycle, `pc_load_o`, `push_c_o` and `push_d_o` are high. `push_c_data_o` equals `pc_i`, `push_d_data_o` equals `sr_i`, and `pc_vec_o` equals the level times two (level 1 gives 0x0002).
- R9: A dispatch clears the chosen pending bit and marks an exception in progress. A raise of that same level in the dispatch cycle leaves the bit set.
- R10: A high `rti_i` clears the in-progress state, so a later check can dispatch again.
- R11: Reset clears all pending levels and the in-progress state.
- R12: Dispatch only happens in a cycle where `check_i` is high, and at most once per such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 8 | Per-level raise strobes |
| ext_flag_i | input | 1 | External-interrupt flag from the control register |
| sr_i | input | 16 | Current status word |
| pc_i | input | 16 | Current program counter |
| check_i | input | 1 | Evaluate dispatch this cycle |
| rti_i | input | 1 | Return from interrupt, releases the in-progress state |
| pc_load_o | output | 1 | Load program counter with `pc_vec_o` |
| pc_vec_o | output | 16 | Handler address, level times two |
| push_c_o | output | 1 | Push onto the call stack |
| push_c_data_o | output | 16 | Return PC to push |
| push_d_o | output | 1 | Push onto the status stack |
| push_d_data_o | output | 16 | Status word to push |
| ext_clr_o | output | 1 | Clear pulse for the control-register flag |

## Verification
The bench targets the cases where a plausible design would dispatch too eagerly. Examples are a second level dispatched while a handler is still in progress, or level 0 chosen when only it is pending. Another is a low-priority level dispatched with the global enable clear when only the mailbox should bypass it. A design that scanned upward would pick the lowest of several pending levels. One that let clear win over a same-cycle raise would lose a re-raised level. A design that consumed the mailbox flag without its enable would pulse `ext_clr_o` and dispatch level 5 where neither should happen.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;
  localparam int unsigned DEF_LEVELS = 8;
  localparam int unsigned DEF_WORD_W = 16;

  function automatic int unsigned lvl_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/exc_mbox_gate.sv
module exc_mbox_gate #(
  parameter int unsigned SR_W    = 16,
  parameter int unsigned XIE_BIT = 11
) (
  input  logic            ext_flag_i,
  input  logic [SR_W-1:0] sr_i,
  output logic            set_o
);
  assign set_o = ext_flag_i & sr_i[XIE_BIT];
endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int unsigned NLVL = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NLVL-1:0] set_i,
  input  logic [NLVL-1:0] clr_i,
  output logic [NLVL-1:0] pend_o
);
  logic [NLVL-1:0] pend_q;

  // set wins over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/exc_active.sv
module exc_active (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic active_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    active_q <= 1'b0;
    else if (set_i) active_q <= 1'b1;
    else if (clr_i) active_q <= 1'b0;
  end

  assign active_o = active_q;
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int unsigned NLVL       = 8,
  parameter int unsigned MBOX_LEVEL = 5,
  parameter int unsigned SR_W       = 16,
  parameter int unsigned GIE_BIT    = 9,
  parameter int unsigned LW         = 3
) (
  input  logic [NLVL-1:0] pend_i,
  input  logic [SR_W-1:0] sr_i,
  output logic            valid_o,
  output logic [LW-1:0]   lvl_o
);
  logic [NLVL-1:0] elig;

  // level 0 excluded from scan; mailbox bypasses global enable
  assign elig[0] = 1'b0;
  for (genvar g = 1; g < NLVL; g++) begin : g_elig
    if (g == MBOX_LEVEL) begin : g_mbox
      assign elig[g] = pend_i[g];
    end else begin : g_norm
      assign elig[g] = pend_i[g] & sr_i[GIE_BIT];
    end
  end

  // ascending loop, last hit = highest level
  always_comb begin
    valid_o = 1'b0;
    lvl_o   = '0;
    for (int i = 1; i < NLVL; i++) begin
      if (elig[i]) begin
        valid_o = 1'b1;
        lvl_o   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = DEF_LEVELS,
  parameter int unsigned MBOX_LEVEL = 5,
  parameter int unsigned PC_W       = DEF_WORD_W,
  parameter int unsigned SR_W       = DEF_WORD_W,
  parameter int unsigned GIE_BIT    = 9,
  parameter int unsigned XIE_BIT    = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] raise_i,
  input  logic                  ext_flag_i,
  input  logic [SR_W-1:0]       sr_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic                  check_i,
  input  logic                  rti_i,
  output logic                  pc_load_o,
  output logic [PC_W-1:0]       pc_vec_o,
  output logic                  push_c_o,
  output logic [PC_W-1:0]       push_c_data_o,
  output logic                  push_d_o,
  output logic [SR_W-1:0]       push_d_data_o,
  output logic                  ext_clr_o
);
  localparam int unsigned LW = lvl_w(NUM_LEVELS);

  logic                  mbox_set;
  logic [NUM_LEVELS-1:0] pend;
  logic [NUM_LEVELS-1:0] set_mask;
  logic [NUM_LEVELS-1:0] clr_mask;
  logic                  sel_valid;
  logic [LW-1:0]         sel_lvl;
  logic                  active;
  logic                  fire;

  exc_mbox_gate #(.SR_W(SR_W), .XIE_BIT(XIE_BIT)) u_gate (
    .ext_flag_i (ext_flag_i),
    .sr_i       (sr_i),
    .set_o      (mbox_set)
  );

  exc_pick #(
    .NLVL(NUM_LEVELS), .MBOX_LEVEL(MBOX_LEVEL), .SR_W(SR_W),
    .GIE_BIT(GIE_BIT), .LW(LW)
  ) u_pick (
    .pend_i  (pend),
    .sr_i    (sr_i),
    .valid_o (sel_valid),
    .lvl_o   (sel_lvl)
  );

  assign fire = check_i & ~active & sel_valid;

  always_comb begin
    set_mask = raise_i;
    set_mask[MBOX_LEVEL] = raise_i[MBOX_LEVEL] | mbox_set;
    clr_mask = '0;
    if (fire) clr_mask[sel_lvl] = 1'b1;
  end

  exc_pending #(.NLVL(NUM_LEVELS)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_mask),
    .clr_i  (clr_mask),
    .pend_o (pend)
  );

  exc_active u_act (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (fire),
    .clr_i    (rti_i),
    .active_o (active)
  );

  assign pc_load_o     = fire;
  assign pc_vec_o      = PC_W'(sel_lvl) << 1;
  assign push_c_o      = fire;
  assign push_c_data_o = pc_i;
  assign push_d_o      = fire;
  assign push_d_data_o = sr_i;
  assign ext_clr_o     = mbox_set;
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk #(
  parameter int unsigned NUM_LEVELS = 8,
  parameter int unsigned MBOX_LEVEL = 5,
  parameter int unsigned PC_W       = 16,
  parameter int unsigned SR_W       = 16,
  parameter int unsigned GIE_BIT    = 9,
  parameter int unsigned XIE_BIT    = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ext_flag_i,
  input logic [SR_W-1:0] sr_i,
  input logic [PC_W-1:0] pc_i,
  input logic            check_i,
  input logic            pc_load_o,
  input logic [PC_W-1:0] pc_vec_o,
  input logic            push_c_o,
  input logic [PC_W-1:0] push_c_data_o,
  input logic            push_d_o,
  input logic [SR_W-1:0] push_d_data_o,
  input logic            ext_clr_o
);
  assert_back_to_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);

  assert_push_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (push_c_o && push_d_o && push_c_data_o == pc_i && push_d_data_o == sr_i));

  assert_no_vec_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (pc_vec_o != '0 && pc_vec_o[0] == 1'b0));

  assert_mbox_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o && !sr_i[GIE_BIT]) |-> pc_vec_o == PC_W'(MBOX_LEVEL * 2));

  assert_clr_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_clr_o |-> (ext_flag_i && sr_i[XIE_BIT]));

  assert_clr_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_flag_i && sr_i[XIE_BIT]) |-> ext_clr_o);

  assert_needs_check_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> check_i);
endmodule

bind exc_dispatch exc_dispatch_chk #(
  .NUM_LEVELS(NUM_LEVELS), .MBOX_LEVEL(MBOX_LEVEL), .PC_W(PC_W),
  .SR_W(SR_W), .GIE_BIT(GIE_BIT), .XIE_BIT(XIE_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_flag_i(ext_flag_i), .sr_i(sr_i),
  .pc_i(pc_i), .check_i(check_i), .pc_load_o(pc_load_o), .pc_vec_o(pc_vec_o),
  .push_c_o(push_c_o), .push_c_data_o(push_c_data_o), .push_d_o(push_d_o),
  .push_d_data_o(push_d_data_o), .ext_clr_o(ext_clr_o)
);

// File: tb/exc_dispatch_tb.sv
module exc_dispatch_tb;
  localparam logic [15:0] GIE = 16'h0200;
  localparam logic [15:0] XIE = 16'h0800;
  localparam int MBOX = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  raise_i = '0;
  logic        ext_flag_i = 1'b0;
  logic [15:0] sr_i = '0;
  logic [15:0] pc_i = '0;
  logic        check_i = 1'b0;
  logic        rti_i = 1'b0;
  logic        pc_load_o, push_c_o, push_d_o, ext_clr_o;
  logic [15:0] pc_vec_o, push_c_data_o, push_d_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_pend;
  bit         m_act;

  always #2 clk_i = ~clk_i;

  exc_dispatch u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .raise_i(raise_i), .ext_flag_i(ext_flag_i),
    .sr_i(sr_i), .pc_i(pc_i), .check_i(check_i), .rti_i(rti_i),
    .pc_load_o(pc_load_o), .pc_vec_o(pc_vec_o), .push_c_o(push_c_o),
    .push_c_data_o(push_c_data_o), .push_d_o(push_d_o),
    .push_d_data_o(push_d_data_o), .ext_clr_o(ext_clr_o)
  );

  function automatic int exp_pick(input logic [7:0] p, input logic [15:0] s);
    for (int i = 7; i >= 1; i--)
      if (p[i] && (s[9] || i == MBOX)) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, update model at posedge
  task automatic cyc(input logic [7:0] r, input bit ext, input logic [15:0] s,
                     input bit ck, input bit rt, input string tag);
    int  lvl;
    bit  disp, mset;
    @(negedge clk_i);
    raise_i = r; ext_flag_i = ext; sr_i = s; check_i = ck; rti_i = rt;
    pc_i = 16'($urandom);
    #1;
    lvl  = exp_pick(m_pend, s);
    disp = ck && !m_act && lvl >= 0;
    mset = ext && s[11];
    chk({tag, " load"}, 32'(pc_load_o), 32'(disp));
    chk({tag, " R2 clr"}, 32'(ext_clr_o), 32'(mset));
    if (disp) begin
      chk({tag, " R8 vec"}, 32'(pc_vec_o), 32'(lvl * 2));
      chk({tag, " R8 pushes"}, {30'd0, push_c_o, push_d_o}, 32'd3);
      chk({tag, " R8 pc data"}, 32'(push_c_data_o), 32'(pc_i));
      chk({tag, " R8 sr data"}, 32'(push_d_data_o), 32'(s));
    end
    @(posedge clk_i);
    if (disp) m_pend[lvl] = 1'b0;
    m_pend = m_pend | r | (mset ? 8'(1 << MBOX) : 8'd0);
    if (disp) m_act = 1'b1;
    else if (rt) m_act = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    raise_i = '0; ext_flag_i = 0; check_i = 0; rti_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_pend = '0; m_act = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_pend = '0; m_act = 0;
    do_reset();

    // R11 reset state
    cyc(8'h00, 0, GIE, 1, 0, "R11 reset");
    chk("R11 no load after reset", 32'(pc_load_o), 0);
    // R3 nothing pending
    cyc(8'h00, 0, GIE, 1, 0, "R3 idle");
    // R1 raise level 1, R8 vector 2
    cyc(8'h02, 0, GIE, 0, 0, "R1 raise");
    cyc(8'h00, 0, GIE, 1, 0, "R8 lvl1");
    chk("R8 level1 vector", 32'(pc_vec_o), 32'h2);
    // R4 blocked while active, pending kept
    cyc(8'h80, 0, GIE, 1, 0, "R4 blocked");
    chk("R4 no load while active", 32'(pc_load_o), 0);
    cyc(8'h00, 0, GIE, 1, 1, "R10 rti");
    cyc(8'h00, 0, GIE, 1, 0, "R4 kept");
    chk("R4 kept level 7", 32'(pc_vec_o), 32'hE);
    cyc(8'h00, 0, GIE, 0, 1, "R10 rti");
    // R6 level 0 never dispatched
    cyc(8'h01, 0, GIE, 0, 0, "R6 raise0");
    cyc(8'h00, 0, GIE, 1, 0, "R6 lvl0");
    chk("R6 level0 ignored", 32'(pc_load_o), 0);
    // R7 mailbox bypass, ineligible kept
    cyc(8'h28, 0, 16'h0000, 0, 0, "R7 raise");
    cyc(8'h00, 0, 16'h0000, 1, 0, "R7 bypass");
    chk("R7 mailbox vector", 32'(pc_vec_o), 32'hA);
    cyc(8'h00, 0, 16'h0000, 0, 1, "R10 rti");
    cyc(8'h00, 0, 16'h0000, 1, 0, "R7 gated");
    chk("R7 level3 gated", 32'(pc_load_o), 0);
    cyc(8'h00, 0, GIE, 1, 0, "R7 enabled");
    chk("R7 level3 kept", 32'(pc_vec_o), 32'h6);
    cyc(8'h00, 0, GIE, 0, 1, "R10 rti");
    // R2 mailbox gate
    cyc(8'h00, 1, 16'h0000, 0, 0, "R2 no xie");
    chk("R2 no clr without enable", 32'(ext_clr_o), 0);
    cyc(8'h00, 0, 16'h0000, 1, 0, "R2 nothing set");
    chk("R2 no mailbox set", 32'(pc_load_o), 0);
    cyc(8'h00, 1, XIE, 0, 0, "R2 taken");
    chk("R2 clr pulse", 32'(ext_clr_o), 1);
    cyc(8'h00, 0, 16'h0000, 1, 0, "R2 dispatch");
    chk("R2 mailbox vector", 32'(pc_vec_o), 32'hA);
    cyc(8'h00, 0, GIE, 0, 1, "R10 rti");
    // R12 no check, no dispatch
    cyc(8'h10, 0, GIE, 0, 0, "R12 raise");
    cyc(8'h00, 0, GIE, 0, 0, "R12 nocheck");
    chk("R12 no load without check", 32'(pc_load_o), 0);
    // R9 same-cycle raise survives clear
    cyc(8'h10, 0, GIE, 1, 0, "R9 fire+raise");
    chk("R9 vector 8", 32'(pc_vec_o), 32'h8);
    cyc(8'h00, 0, GIE, 0, 1, "R10 rti");
    cyc(8'h00, 0, GIE, 1, 0, "R9 reraised");
    chk("R9 level4 still pending", 32'(pc_vec_o), 32'h8);
    cyc(8'h00, 0, GIE, 0, 1, "R10 rti");
    // R5 priority
    cyc(8'h54, 0, GIE, 0, 0, "R5 raise");
    cyc(8'h00, 0, GIE, 1, 0, "R5 pick");
    chk("R5 highest wins", 32'(pc_vec_o), 32'hC);
    // R11 mid-run reset
    do_reset();
    cyc(8'h00, 0, GIE, 1, 0, "R11 after reset");
    chk("R11 pending cleared", 32'(pc_load_o), 0);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      logic [7:0]  r;
      logic [15:0] s;
      r = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      s = 16'($urandom);
      cyc(r, ($urandom % 5 == 0), s, ($urandom % 4 != 0), ($urandom % 6 == 0), "R5 random");
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule